// File: doc/BRIEF.md
# SPI Slave Transceiver with Phase-Dependent Framing

This block is a full-duplex SPI slave clocked by a fast system clock. It oversamples the external serial clock, the active-low select line and the MOSI line, finds serial clock edges in the system clock domain, and exchanges one word per eight serial clocks. The outgoing word comes from a parallel transmit holding register and goes out on MISO. The incoming word from MOSI is placed in a parallel receive register.

How a word is framed depends on the phase setting. With phase 0, each select assertion frames exactly one word, and the first bit appears on MISO as soon as select falls. With phase 1, select may stay low while several words follow back to back, and every eighth clock closes a word. Three flags report the state of the link: receive-full, overflow and mode fault. The mode-fault flag can be masked. MISO is driven only while the block is selected as a slave. It is left undriven at all other times, so several slaves can share the line.

Top module: `spi_tgt`

## Requirements
- R1: The block acts as a slave only when `cfg_master` is 0 and select is low. Only then is `miso_oe` 1. With `cfg_master` = 1, serial clocks are ignored and no word is received.
- R2: While `ss_n_in` is high, `miso_oe` is 0, which leaves MISO at high impedance.
- R3: A word is eight serial clock cycles, most-significant bit first. MOSI bits are assembled into `rx_data`, and MISO carries the transmit register contents in the same order.
- R4: `cfg_cpol` sets the idle level of the serial clock. The leading edge is the rising edge for CPOL 0 and the falling edge for CPOL 1. With CPHA 0, MOSI is sampled on the leading edge and MISO changes on the trailing edge. With CPHA 1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. All four combinations transfer correctly.
- R5: With CPHA 0, the falling edge of select starts a word and puts bit 7 of the transmit register on MISO before any serial clock edge. Select returns high between words.
- R6: With CPHA 1, select may stay low across back-to-back words. Each group of eight clocks is its own word, and the transmit register is reloaded on the first leading edge of each word.
- R7: When a word completes and `rx_full` is 0, the word is written to `rx_data` and `rx_full` becomes 1. A one-cycle pulse on `rx_read` clears `rx_full`.
- R8: If a word completes while `rx_full` is still 1, `ovf` is set and the new word is discarded, so `rx_data` keeps the earlier word. A pulse on `err_clr` clears `ovf`.
- R9: If select rises before the eighth bit, the partial word is dropped. The bit count restarts, so the next full word is received intact and `rx_full` is not set by the aborted word.
- R10: If select rises mid-word while `cfg_mfault_en` is 1, `mfault` is set. `err_clr` clears it. While `cfg_mfault_en` is 0, select activity never sets `mfault`.
- R11: A pulse on `tx_load` writes `tx_data` into the transmit holding register. The next word to start sends that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role selected (slave logic idle) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_mfault_en | input | 1 | Enables setting of the mode-fault flag |
| sck_in | input | 1 | External serial clock |
| ss_n_in | input | 1 | External select, active low |
| mosi_in | input | 1 | Serial data from master |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for MISO pad |
| tx_data | input | 8 | Word to transmit |
| tx_load | input | 1 | Writes tx_data into transmit holding register |
| rx_data | output | 8 | Last accepted received word |
| rx_read | input | 1 | Clears rx_full |
| rx_full | output | 1 | Received word waiting |
| ovf | output | 1 | Word lost because rx_full was set |
| mfault | output | 1 | Select rose in mid-word |
| err_clr | input | 1 | Clears ovf and mfault |

## Verification
A bit counter that has gone wrong has two visible effects. The word boundary moves, so `rx_data` reads as a rotated value, and `rx_full` rises on the wrong clock. Both show at the end of the first word after the fault, at most eight serial clocks later. A stale transmit shift register shows on MISO at the next sampling edge, and the bench catches it when it compares the byte the master collected. Wrong flag state, such as a missed overflow or an unmasked mode fault, appears on `ovf` or `mfault` three system clocks after the serial edge or select edge that caused it.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int unsigned WORD_W_DEF      = 8;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Serial-clock and select events seen in the system clock domain
    typedef struct packed {
        logic sample;   // capture MOSI
        logic launch;   // advance MISO
        logic ss_fall;  // select asserted
        logic ss_rise;  // select released
    } spi_ev_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int unsigned   W       = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[g] <= RST_VAL;
            else         stg_q[g] <= stg_d[g];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_tgt_edges.sv
module spi_tgt_edges
    import spi_tgt_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    cpol_i,
    input  logic    cpha_i,
    input  logic    sck_s_i,
    input  logic    ss_s_i,
    output spi_ev_t ev_o
);

    typedef struct packed {
        logic sck_prev;
        logic ss_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rise, fall, lead, trail;

    always_comb begin
        st_d.sck_prev = sck_s_i;
        st_d.ss_prev  = ss_s_i;

        rise  = sck_s_i & ~st_q.sck_prev;
        fall  = ~sck_s_i & st_q.sck_prev;
        lead  = cpol_i ? fall : rise;
        trail = cpol_i ? rise : fall;

        ev_o.sample  = cpha_i ? trail : lead;
        ev_o.launch  = cpha_i ? lead  : trail;
        ev_o.ss_fall = ~ss_s_i & st_q.ss_prev;
        ev_o.ss_rise = ss_s_i & ~st_q.ss_prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sck_prev <= 1'b0;
            st_q.ss_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: one serial edge is either a sample or a launch, never both
    p_single_role_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ev_o.sample, ev_o.launch}));

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
    import spi_tgt_pkg::*;
#(
    parameter int unsigned W = WORD_W_DEF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,       // slave role selected
    input  logic         ss_s_i,     // synchronised select, active low
    input  logic         cpha_i,
    input  logic         mosi_s_i,
    input  spi_ev_t      ev_i,
    input  logic [W-1:0] tx_word_i,
    output logic         miso_o,
    output logic         done_o,
    output logic [W-1:0] rx_word_o,
    output logic         abort_o
);

    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  tx_sh;
        logic [W-2:0]  rx_sh;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic active;

    always_comb begin
        st_d      = st_q;
        done_o    = 1'b0;
        abort_o   = 1'b0;
        active    = en_i & ~ss_s_i;
        rx_word_o = {st_q.rx_sh, mosi_s_i};

        if (!en_i) begin
            st_d.cnt = '0;
        end else if (ev_i.ss_rise) begin
            abort_o  = (st_q.cnt != '0);
            st_d.cnt = '0;
        end else if (active) begin
            if (ev_i.ss_fall && !cpha_i) begin
                st_d.tx_sh = tx_word_i;
            end
            if (ev_i.launch) begin
                if (cpha_i && st_q.cnt == '0) st_d.tx_sh = tx_word_i;
                else                          st_d.tx_sh = {st_q.tx_sh[W-2:0], 1'b0};
            end
            if (ev_i.sample) begin
                st_d.rx_sh = rx_word_o[W-2:0];
                if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                    done_o   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign miso_o = st_q.tx_sh[W-1];

    // R9: a select release always restarts the bit count
    p_restart_on_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && ev_i.ss_rise) |=> (st_q.cnt == '0));

endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
    import spi_tgt_pkg::*;
#(
    parameter int unsigned W      = WORD_W_DEF,
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cfg_master,
    input  logic         cfg_cpol,
    input  logic         cfg_cpha,
    input  logic         cfg_mfault_en,
    input  logic         sck_in,
    input  logic         ss_n_in,
    input  logic         mosi_in,
    output logic         miso_out,
    output logic         miso_oe,
    input  logic [W-1:0] tx_data,
    input  logic         tx_load,
    output logic [W-1:0] rx_data,
    input  logic         rx_read,
    output logic         rx_full,
    output logic         ovf,
    output logic         mfault,
    input  logic         err_clr
);

    typedef struct packed {
        logic [W-1:0] tx_buf;
        logic [W-1:0] rx_buf;
        logic         full;
        logic         ovf;
        logic         mf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [2:0]   pins_s;
    logic         sck_s, ss_s, mosi_s;
    spi_ev_t      ev;
    logic         done, abort, en, full_eff;
    logic [W-1:0] rx_word;

    spi_tgt_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({sck_in, ss_n_in, mosi_in}),
        .q_o   (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign ss_s   = pins_s[1];
    assign mosi_s = pins_s[0];
    assign en     = ~cfg_master;

    spi_tgt_edges u_edges (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cpol_i (cfg_cpol),
        .cpha_i (cfg_cpha),
        .sck_s_i(sck_s),
        .ss_s_i (ss_s),
        .ev_o   (ev)
    );

    spi_tgt_shifter #(.W(W)) u_shift (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en),
        .ss_s_i   (ss_s),
        .cpha_i   (cfg_cpha),
        .mosi_s_i (mosi_s),
        .ev_i     (ev),
        .tx_word_i(st_q.tx_buf),
        .miso_o   (miso_out),
        .done_o   (done),
        .rx_word_o(rx_word),
        .abort_o  (abort)
    );

    always_comb begin
        st_d     = st_q;
        full_eff = st_q.full & ~rx_read;
        st_d.full = full_eff;
        if (err_clr) begin
            st_d.ovf = 1'b0;
            st_d.mf  = 1'b0;
        end
        if (tx_load) st_d.tx_buf = tx_data;
        if (done) begin
            if (full_eff) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.full   = 1'b1;
                st_d.rx_buf = rx_word;
            end
        end
        if (abort && cfg_mfault_en) st_d.mf = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign miso_oe = en & ~ss_s;
    assign rx_data = st_q.rx_buf;
    assign rx_full = st_q.full;
    assign ovf     = st_q.ovf;
    assign mfault  = st_q.mf;

    // R7: the full flag only rises after a completed word
    p_full_after_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.full) |-> $past(done));

    // R8: overflow only arises while a word was already waiting
    p_ovf_needs_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.ovf) |-> $past(st_q.full));

    // R8: the waiting word survives an overflow
    p_ovf_keeps_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.ovf) |-> $stable(st_q.rx_buf));

    // R10: a masked mode fault never appears
    p_mf_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_mfault_en && !st_q.mf) |=> !st_q.mf);

endmodule

// File: tb/spi_tgt_tb.sv
module spi_tgt_tb_top;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_mfault_en = 1'b0;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso_out, miso_oe;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0, rx_read = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, ovf, mfault;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_tgt dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_mfault_en(cfg_mfault_en),
        .sck_in(sck), .ss_n_in(ss_n), .mosi_in(mosi),
        .miso_out(miso_out), .miso_oe(miso_oe),
        .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_read(rx_read), .rx_full(rx_full),
        .ovf(ovf), .mfault(mfault), .err_clr(err_clr)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [7:0] v);
        tx_data = v; tx_load = 1'b1; tick(1); tx_load = 1'b0; tick(1);
    endtask

    task automatic pulse_read();
        rx_read = 1'b1; tick(1); rx_read = 1'b0; tick(4);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(4);
    endtask

    task automatic set_mode(input logic cpol, input logic cpha);
        cfg_cpol = cpol; cfg_cpha = cpha; sck = cpol; tick(8);
    endtask

    task automatic sel(input logic lvl);
        ss_n = lvl; tick(HALF);
    endtask

    // master side: shift n bits of mo starting at bit 7, collecting MISO
    task automatic shift_bits(input logic [7:0] mo, input int n, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            if (!cfg_cpha) begin
                mosi = mo[i]; tick(HALF);
                got[i] = miso_out;
                sck = ~cfg_cpol; tick(HALF);
                sck = cfg_cpol;
            end else begin
                sck = ~cfg_cpol; mosi = mo[i]; tick(HALF);
                got[i] = miso_out;
                sck = cfg_cpol; tick(HALF);
            end
        end
        tick(HALF);
    endtask

    task automatic t_reset();
        check("R2 oe at reset", miso_oe, 0);
        check("R7 full at reset", rx_full, 0);
        check("R8 ovf at reset", ovf, 0);
        check("R10 mfault at reset", mfault, 0);
    endtask

    task automatic t_select();
        sel(1'b0);
        check("R1 oe when selected", miso_oe, 1);
        cfg_master = 1'b1; tick(2);
        check("R1 oe in master role", miso_oe, 0);
        cfg_master = 1'b0; tick(2);
        sel(1'b1);
        check("R2 oe when deselected", miso_oe, 0);
    endtask

    task automatic t_word(input logic cpol, input logic cpha, input logic [7:0] tx, input logic [7:0] mo);
        logic [7:0] got;
        set_mode(cpol, cpha);
        pulse_load(tx);
        sel(1'b0);
        if (!cpha) check("R5 first bit on select", miso_out, tx[7]);
        shift_bits(mo, 8, got);
        sel(1'b1);
        check("R3 R4 miso word", got, tx);
        check("R3 R4 rx word", rx_data, mo);
        check("R7 full set", rx_full, 1);
        pulse_read();
        check("R7 full cleared", rx_full, 0);
    endtask

    task automatic t_back_to_back();
        logic [7:0] g1, g2;
        set_mode(1'b1, 1'b1);
        pulse_load(8'hC3);
        sel(1'b0);
        shift_bits(8'h5A, 8, g1);
        check("R6 first rx", rx_data, 8'h5A);
        pulse_read();
        pulse_load(8'h3C);
        shift_bits(8'hA7, 8, g2);
        sel(1'b1);
        check("R6 first miso", g1, 8'hC3);
        check("R11 reloaded miso", g2, 8'h3C);
        check("R6 second rx", rx_data, 8'hA7);
        check("R8 no ovf after read", ovf, 0);
        pulse_read();
    endtask

    task automatic t_overflow();
        logic [7:0] g;
        set_mode(1'b0, 1'b0);
        sel(1'b0); shift_bits(8'h11, 8, g); sel(1'b1);
        sel(1'b0); shift_bits(8'h22, 8, g); sel(1'b1);
        check("R8 ovf set", ovf, 1);
        check("R8 word kept", rx_data, 8'h11);
        pulse_clr();
        check("R8 ovf cleared", ovf, 0);
        check("R8 full still set", rx_full, 1);
        pulse_read();
    endtask

    task automatic t_abort();
        logic [7:0] g;
        set_mode(1'b0, 1'b1);
        cfg_mfault_en = 1'b1;
        pulse_load(8'h96);
        sel(1'b0); shift_bits(8'hFF, 3, g); sel(1'b1);
        check("R10 mfault set", mfault, 1);
        check("R9 partial dropped", rx_full, 0);
        pulse_clr();
        check("R10 mfault cleared", mfault, 0);
        sel(1'b0); shift_bits(8'h6D, 8, g); sel(1'b1);
        check("R9 next word intact", rx_data, 8'h6D);
        check("R9 next miso intact", g, 8'h96);
        pulse_read();
        cfg_mfault_en = 1'b0;
        sel(1'b0); shift_bits(8'h00, 5, g); sel(1'b1);
        check("R10 masked fault", mfault, 0);
        check("R9 masked partial dropped", rx_full, 0);
    endtask

    task automatic t_master_role();
        logic [7:0] g;
        set_mode(1'b0, 1'b0);
        cfg_master = 1'b1;
        sel(1'b0); shift_bits(8'hE1, 8, g); sel(1'b1);
        check("R1 no rx in master role", rx_full, 0);
        cfg_master = 1'b0; tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_select();
        t_word(1'b0, 1'b0, 8'hA5, 8'h3E);
        t_word(1'b1, 1'b0, 8'h81, 8'hC7);
        t_word(1'b0, 1'b1, 8'h4B, 8'hD2);
        t_word(1'b1, 1'b1, 8'h1F, 8'h80);
        t_back_to_back();
        t_overflow();
        t_abort();
        t_master_role();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule